// File: doc/BRIEF.md
# Thread Interrupt Context Presenter

This block keeps the interrupt management state of a single hardware thread. The state is split into four rings of sixteen bytes each: user, operating system, pool and physical. A presentation request names a ring and a priority. The block folds it into that ring's pending-priority bitmap. When the most favored pending priority of a ring is numerically lower than the ring's current priority, the block raises an interrupt line. The OS ring drives the OS line. The pool and physical rings together drive the hypervisor line.

Software reaches the rings through one byte-wide access port. The port selects one of four page views. Pages 0 (hardware) and 1 (hypervisor) reach every ring. Pages 2 (OS) and 3 (user) cannot reach the pool and physical rings.

Each ring uses these byte offsets:
- Offset 0 holds the pending bitmap.
- Offset 1 holds the current priority.
- Offset 2 reads back the most favored pending priority.
- Offset 3 is the acknowledge location.
- Offsets 4 to 15 are plain context storage.

Top module: `thread_irq_context`

## Requirements
- R1: After reset every pending bitmap, and every storage byte at offsets 4 to 15, reads 0x00. Every current priority (offset 1) and every most-favored priority (offset 2) reads 0xFF. Both interrupt outputs are low.
- R2: A presentation of priority p in 0..7 on ring r sets bit (7-p) of ring r's pending bitmap, read at offset 0. Repeated presentations accumulate bits.
- R3: A presentation with a priority above 7 (for example 9 or 0xFF) changes no pending bit.
- R4: Offset 2 reads the lowest-numbered priority whose bit is set in the pending bitmap, or 0xFF when the bitmap is empty.
- R5: `irq_os` is high exactly when ring 1 (OS) has a most-favored priority numerically below its current priority.
- R6: `irq_hv` is high exactly when ring 2 (pool) or ring 3 (physical) meets that same condition. Ring 0 (user) drives neither output.
- R7: A read of offset 3 returns the most-favored priority. It also clears that priority's bit from the pending bitmap and loads the priority into the current priority, so the ring's output goes low.
- R8: A read of offset 3 with an empty bitmap returns 0xFF, leaves the bitmap empty and sets the current priority to 0xFF.
- R9: An access through page 2 or page 3 that targets ring 2 or ring 3 reads 0x00. Writes and acknowledges through it have no effect.
- R10: Pages 0 and 1 reach all rings. A write to offset 0 or offset 1 replaces that byte. Offsets 4 to 15 store and return written bytes.
- R11: Writes to offsets 2 and 3 are ignored.
- R12: Read data appears on `acc_rdata` one cycle after the read request and holds until the next read.
- R13: When a presentation and a write of the pending bitmap hit the same ring in one cycle, the bitmap becomes the written byte with the presented bit also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Presentation request strobe |
| req_ring | input | 2 | Ring targeted by the presentation |
| req_prio | input | 8 | Priority of the presentation |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_page | input | 2 | Page view: 0 hardware, 1 hypervisor, 2 OS, 3 user |
| acc_ring | input | 2 | Ring addressed by the access |
| acc_ofs | input | 4 | Byte offset within the ring |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| irq_os | output | 1 | OS interrupt line |
| irq_hv | output | 1 | Hypervisor interrupt line |

## Verification
The bench builds the block with its default parameters:
- eight-bit bytes
- eight priority levels
- sixteen-byte rings
- pages 2 and up treated as unprivileged
- rings 2 and up treated as privileged

With eight levels filling the byte, every pending bit maps to a priority, so both ends of the mapping are exercised: priority 0 on bit 7 and priority 7 on bit 0. Priorities 9 and 0xFF fall outside the active range and are shown to be dropped. Sixteen-byte rings leave twelve storage bytes per ring. With the privilege split at 2, both a permitted OS-page access and a refused one are reachable.

// File: rtl/tic_pkg.sv
package tic_pkg;

   typedef enum logic [1:0] {
      RING_USER = 2'd0,
      RING_OS   = 2'd1,
      RING_POOL = 2'd2,
      RING_PHYS = 2'd3
   } ring_e;

   typedef enum logic [1:0] {
      VIEW_HW   = 2'd0,
      VIEW_HV   = 2'd1,
      VIEW_OS   = 2'd2,
      VIEW_USER = 2'd3
   } view_e;

   localparam int NUM_RINGS  = 4;
   localparam int RING_IDX_W = 2;

   localparam int OFS_PEND = 0;
   localparam int OFS_CPPR = 1;
   localparam int OFS_PIPR = 2;
   localparam int OFS_ACK  = 3;
   localparam int OFS_STORE_BASE = 4;

endpackage

// File: rtl/tic_prio_enc.sv
module tic_prio_enc #(
   parameter int DATA_W   = 8,
   parameter int NUM_PRIO = 8
) (
   input  logic [DATA_W-1:0] pend,
   output logic [DATA_W-1:0] prio
);

   if (NUM_PRIO < 1 || NUM_PRIO > DATA_W) begin : g_bad
      $error("tic_prio_enc: NUM_PRIO must lie in 1..DATA_W");
   end

   always_comb begin
      prio = '1;
      for (int i = 0; i < NUM_PRIO; i++) begin
         if (pend[i]) prio = DATA_W'(NUM_PRIO - 1 - i);
      end
   end

endmodule

// File: rtl/tic_view_decode.sv
module tic_view_decode #(
   parameter int UNPRIV_PAGE_MIN = 2,
   parameter int PRIV_RING_MIN   = 2
) (
   input  logic [1:0] page,
   input  logic [1:0] ring,
   output logic       allow
);

   if (UNPRIV_PAGE_MIN < 1) begin : g_bad_page
      $error("tic_view_decode: page 0 must stay fully privileged");
   end

   if (UNPRIV_PAGE_MIN >= 4 || PRIV_RING_MIN >= 4) begin : g_open
      assign allow = 1'b1;
   end else begin : g_split
      localparam logic [1:0] PG_LIM = 2'(UNPRIV_PAGE_MIN);
      localparam logic [1:0] RG_LIM = 2'(PRIV_RING_MIN);
      assign allow = !((page >= PG_LIM) && (ring >= RG_LIM));
   end

endmodule

// File: rtl/tic_ring.sv
module tic_ring
   import tic_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NUM_PRIO   = 8,
   parameter int RING_BYTES = 16,
   localparam int OFS_W     = $clog2(RING_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_in,
   input  logic [DATA_W-1:0] req_prio,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] pipr,
   output logic              signal
);

   localparam int SCR_N = RING_BYTES - OFS_STORE_BASE;
   localparam int SCR_W = (SCR_N > 1) ? $clog2(SCR_N) : 1;
   localparam logic [DATA_W-1:0] LEAST = '1;

   if (RING_BYTES < 8 || (RING_BYTES & (RING_BYTES - 1)) != 0) begin : g_bad
      $error("tic_ring: RING_BYTES must be a power of two, at least 8");
   end

   logic [DATA_W-1:0] pend, cppr;
   logic [DATA_W-1:0] scratch [SCR_N];
   logic              ack;
   logic [SCR_W-1:0]  scr_idx;
   logic [DATA_W-1:0] req_bit, ack_bit, pend_base, pend_next;

   function automatic logic [DATA_W-1:0] prio_bit(input logic [DATA_W-1:0] p);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_PRIO; i++) begin
         if (p == DATA_W'(NUM_PRIO - 1 - i)) m[i] = 1'b1;
      end
      return m;
   endfunction

   tic_prio_enc #(
      .DATA_W   (DATA_W),
      .NUM_PRIO (NUM_PRIO)
   ) u_enc (
      .pend (pend),
      .prio (pipr)
   );

   assign ack     = rd_en && (ofs == OFS_W'(OFS_ACK));
   assign scr_idx = SCR_W'(ofs - OFS_W'(OFS_STORE_BASE));
   assign req_bit = req_in ? prio_bit(req_prio) : '0;
   assign ack_bit = ack ? prio_bit(pipr) : '0;

   always_comb begin
      pend_base = (wr_en && ofs == OFS_W'(OFS_PEND)) ? wdata : pend;
      pend_next = (pend_base & ~ack_bit) | req_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         cppr <= LEAST;
         for (int i = 0; i < SCR_N; i++) scratch[i] <= '0;
      end else begin
         pend <= pend_next;
         if (ack)
            cppr <= pipr;
         else if (wr_en && ofs == OFS_W'(OFS_CPPR))
            cppr <= wdata;
         for (int i = 0; i < SCR_N; i++) begin
            if (wr_en && ofs == OFS_W'(i + OFS_STORE_BASE)) scratch[i] <= wdata;
         end
      end
   end

   always_comb begin
      if (ofs == OFS_W'(OFS_PEND))
         rdata = pend;
      else if (ofs == OFS_W'(OFS_CPPR))
         rdata = cppr;
      else if (ofs == OFS_W'(OFS_PIPR) || ofs == OFS_W'(OFS_ACK))
         rdata = pipr;
      else
         rdata = scratch[scr_idx];
   end

   assign signal = pipr < cppr;

   AST_ACK_LOADS_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> cppr == $past(pipr)); // R7
   AST_ACK_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req_in) |=> !signal); // R7
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !rd_en && !req_in) |=> $stable(pend)); // R2
   AST_REQ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_in && req_prio < DATA_W'(NUM_PRIO)) |=> pipr <= $past(req_prio)); // R2
   AST_PIPR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pipr < DATA_W'(NUM_PRIO)) || (pipr == LEAST)); // R4

endmodule

// File: rtl/thread_irq_context.sv
module thread_irq_context
   import tic_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int NUM_PRIO        = 8,
   parameter int RING_BYTES      = 16,
   parameter int UNPRIV_PAGE_MIN = 2,
   parameter int PRIV_RING_MIN   = 2,
   localparam int OFS_W          = $clog2(RING_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_ring,
   input  logic [DATA_W-1:0] req_prio,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        acc_page,
   input  logic [1:0]        acc_ring,
   input  logic [OFS_W-1:0]  acc_ofs,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              irq_os,
   output logic              irq_hv
);

   if (DATA_W < NUM_PRIO) begin : g_bad_w
      $error("thread_irq_context: DATA_W too small for NUM_PRIO");
   end

   logic                allow;
   logic [DATA_W-1:0]   ring_rdata [NUM_RINGS];
   logic [DATA_W-1:0]   ring_pipr  [NUM_RINGS];
   logic [NUM_RINGS-1:0] ring_sig;
   logic [DATA_W-1:0]   rd_sel;

   tic_view_decode #(
      .UNPRIV_PAGE_MIN (UNPRIV_PAGE_MIN),
      .PRIV_RING_MIN   (PRIV_RING_MIN)
   ) u_view (
      .page  (acc_page),
      .ring  (acc_ring),
      .allow (allow)
   );

   for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
      logic hit;
      assign hit = acc_valid && allow && (acc_ring == RING_IDX_W'(r));

      tic_ring #(
         .DATA_W     (DATA_W),
         .NUM_PRIO   (NUM_PRIO),
         .RING_BYTES (RING_BYTES)
      ) u_ring (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_in   (req_valid && (req_ring == RING_IDX_W'(r))),
         .req_prio (req_prio),
         .wr_en    (hit && acc_write),
         .rd_en    (hit && !acc_write),
         .ofs      (acc_ofs),
         .wdata    (acc_wdata),
         .rdata    (ring_rdata[r]),
         .pipr     (ring_pipr[r]),
         .signal   (ring_sig[r])
      );
   end

   assign rd_sel = allow ? ring_rdata[acc_ring] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_rdata <= '0;
      else if (acc_valid && !acc_write)
         acc_rdata <= rd_sel;
   end

   assign irq_os = ring_sig[RING_OS];
   assign irq_hv = ring_sig[RING_POOL] | ring_sig[RING_PHYS];

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_write) |=> $stable(acc_rdata)); // R12
   AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && acc_page >= 2'(UNPRIV_PAGE_MIN)
       && acc_ring >= 2'(PRIV_RING_MIN) && UNPRIV_PAGE_MIN < 4 && PRIV_RING_MIN < 4)
      |=> acc_rdata == '0); // R9
   AST_OS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_os) |-> $past(req_valid || (acc_valid && acc_write))); // R5
   AST_USER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ring == RING_IDX_W'(RING_USER) && !acc_valid)
      |=> (irq_os == $past(irq_os)) && (irq_hv == $past(irq_hv))); // R6

endmodule

// File: tb/tb_thread_irq_context.sv
`timescale 1ns/1ps
module tb_thread_irq_context;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_ring = '0;
   logic [7:0] req_prio = '0;
   logic       acc_valid = 1'b0;
   logic       acc_write = 1'b0;
   logic [1:0] acc_page = '0;
   logic [1:0] acc_ring = '0;
   logic [3:0] acc_ofs = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       irq_os, irq_hv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   thread_irq_context dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ring(req_ring), .req_prio(req_prio),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
      .acc_ring(acc_ring), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .irq_os(irq_os), .irq_hv(irq_hv)
   );

   // op: 0 present, 1 write, 2 read
   // fields: op page ring ofs data exp_rdata exp_os exp_hv req
   localparam int NV = 28;
   localparam logic [31:0] TBL [NV] = '{
      {2'd2,2'd0,2'd1,4'd1,8'h00,8'hFF,1'b0,1'b0,4'd1},  // R1 cppr after reset
      {2'd2,2'd0,2'd1,4'd2,8'h00,8'hFF,1'b0,1'b0,4'd4},  // R4 empty -> FF
      {2'd0,2'd0,2'd1,4'd0,8'd5 ,8'h00,1'b1,1'b0,4'd5},  // R5 OS raise
      {2'd0,2'd0,2'd1,4'd0,8'd2 ,8'h00,1'b1,1'b0,4'd5},  // R5
      {2'd2,2'd2,2'd1,4'd0,8'h00,8'h24,1'b1,1'b0,4'd2},  // R2 bits 2 and 5
      {2'd2,2'd2,2'd1,4'd2,8'h00,8'h02,1'b1,1'b0,4'd4},  // R4 most favored
      {2'd2,2'd2,2'd1,4'd3,8'h00,8'h02,1'b0,1'b0,4'd7},  // R7 ack
      {2'd2,2'd0,2'd1,4'd1,8'h00,8'h02,1'b0,1'b0,4'd7},  // R7 cppr loaded
      {2'd2,2'd0,2'd1,4'd0,8'h00,8'h04,1'b0,1'b0,4'd7},  // R7 bit cleared
      {2'd0,2'd0,2'd1,4'd0,8'd9 ,8'h00,1'b0,1'b0,4'd3},  // R3 prio 9
      {2'd2,2'd0,2'd1,4'd0,8'h00,8'h04,1'b0,1'b0,4'd3},  // R3 unchanged
      {2'd0,2'd0,2'd0,4'd0,8'd0 ,8'h00,1'b0,1'b0,4'd6},  // R6 user silent
      {2'd2,2'd3,2'd0,4'd0,8'h00,8'h80,1'b0,1'b0,4'd2},  // R2 prio 0 -> bit 7
      {2'd0,2'd0,2'd2,4'd0,8'd7 ,8'h00,1'b0,1'b1,4'd6},  // R6 pool raise
      {2'd2,2'd2,2'd2,4'd0,8'h00,8'h00,1'b0,1'b1,4'd9},  // R9 blocked read
      {2'd2,2'd3,2'd2,4'd3,8'h00,8'h00,1'b0,1'b1,4'd9},  // R9 blocked ack
      {2'd1,2'd2,2'd2,4'd1,8'h00,8'h00,1'b0,1'b1,4'd9},  // R9 blocked write
      {2'd2,2'd1,2'd2,4'd3,8'h00,8'h07,1'b0,1'b0,4'd7},  // R7 hv ack
      {2'd0,2'd0,2'd3,4'd0,8'd3 ,8'h00,1'b0,1'b1,4'd6},  // R6 phys raise
      {2'd1,2'd0,2'd3,4'd1,8'h03,8'h00,1'b0,1'b0,4'd10}, // R10 cppr write
      {2'd1,2'd1,2'd3,4'd2,8'h00,8'h00,1'b0,1'b0,4'd11}, // R11 pipr write
      {2'd2,2'd0,2'd3,4'd2,8'h00,8'h03,1'b0,1'b0,4'd11}, // R11 unchanged
      {2'd1,2'd0,2'd3,4'd5,8'hA5,8'h00,1'b0,1'b0,4'd10}, // R10 store
      {2'd2,2'd1,2'd3,4'd5,8'h00,8'hA5,1'b0,1'b0,4'd10}, // R10 read back
      {2'd1,2'd0,2'd1,4'd0,8'h00,8'h00,1'b0,1'b0,4'd10}, // R10 pend write
      {2'd2,2'd0,2'd1,4'd3,8'h00,8'hFF,1'b0,1'b0,4'd8},  // R8 empty ack
      {2'd2,2'd0,2'd1,4'd1,8'h00,8'hFF,1'b0,1'b0,4'd8},  // R8 cppr FF
      {2'd1,2'd2,2'd1,4'd0,8'h10,8'h00,1'b1,1'b0,4'd10}  // R10 OS page write
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] op, input logic [1:0] page, input logic [1:0] ring,
                         input logic [3:0] ofs, input logic [7:0] data);
      if (op == 2'd0) begin
         req_valid = 1'b1; req_ring = ring; req_prio = data;
      end else begin
         acc_valid = 1'b1; acc_write = (op == 2'd1); acc_page = page;
         acc_ring = ring; acc_ofs = ofs; acc_wdata = data;
      end
      @(negedge clk);
      req_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq_os at reset", {7'd0, irq_os}, 8'd0);
      check("R1 irq_hv at reset", {7'd0, irq_hv}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [31:0] v;
         string tag;
         v = TBL[i];
         run_op(v[31:30], v[29:28], v[27:26], v[25:22], v[21:14]);
         tag = $sformatf("R%0d row %0d", v[3:0], i);
         if (v[31:30] == 2'd2) check({tag, " rdata"}, acc_rdata, v[13:6]);
         check({tag, " irq_os"}, {7'd0, irq_os}, {7'd0, v[5]});
         check({tag, " irq_hv"}, {7'd0, irq_hv}, {7'd0, v[4]});
      end

      // R3: priority 0xFF leaves the user ring bitmap alone
      run_op(2'd0, 2'd0, 2'd0, 4'd0, 8'hFF);
      run_op(2'd2, 2'd0, 2'd0, 4'd0, 8'h00);
      check("R3 prio FF", acc_rdata, 8'h80);

      // R12: read data holds through idle cycles and writes
      run_op(2'd2, 2'd0, 2'd3, 4'd1, 8'h00);
      check("R12 first", acc_rdata, 8'h03);
      repeat (3) @(negedge clk);
      check("R12 idle hold", acc_rdata, 8'h03);
      run_op(2'd1, 2'd0, 2'd3, 4'd6, 8'h77);
      check("R12 write hold", acc_rdata, 8'h03);

      // R13: same-cycle presentation and pending write on ring 2
      req_valid = 1'b1; req_ring = 2'd2; req_prio = 8'd1;
      run_op(2'd1, 2'd0, 2'd2, 4'd0, 8'h01);
      check("R13 irq_hv", {7'd0, irq_hv}, 8'd1);
      run_op(2'd2, 2'd0, 2'd2, 4'd0, 8'h00);
      check("R13 merged bitmap", acc_rdata, 8'h41);

      // R1: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 irq_os in reset", {7'd0, irq_os}, 8'd0);
      check("R1 irq_hv in reset", {7'd0, irq_hv}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(2'd2, 2'd0, 2'd1, 4'd1, 8'h00);
      check("R1 cppr FF", acc_rdata, 8'hFF);
      run_op(2'd2, 2'd0, 2'd2, 4'd0, 8'h00);
      check("R1 bitmap clear", acc_rdata, 8'h00);
      run_op(2'd2, 2'd0, 2'd3, 4'd2, 8'h00);
      check("R1 pipr FF", acc_rdata, 8'hFF);
      run_op(2'd2, 2'd0, 2'd3, 4'd5, 8'h00);
      check("R1 storage clear", acc_rdata, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule